// File: doc/BRIEF.md
# Interrupt and Wait Boundary Controller

This block sits beside an instruction sequencer and decides, at every instruction boundary, whether the core keeps running, services an interrupt or idles on a WAIT instruction. The sequencer pulses an instruction-complete strobe. With that strobe it also reports whether the finishing instruction was a WAIT. The controller samples the maskable request, the interrupt-enable flag and the TEST input at that moment. Non-maskable requests are caught on their rising edge at any time and held until they are served.

A maskable request starts a two-pulse acknowledge sequence, and the vector type byte is sampled on the second pulse. A non-maskable request is served immediately with a fixed type and no acknowledge pulses. Every take raises a request to clear the enable flag and to flush the prefetch queue. The block also supplies the register values the core loads after reset: the flag word, the instruction pointer, the code segment and the remaining segment registers. It raises a load-and-flush strobe for them.

Top module: `intwait_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `init_load_o` and `flush_o` are 1, then `init_load_o` is 0. `take_o`, `ack_o` and `stall_o` are 0 out of reset. The constant outputs are flags 0000h, instruction pointer 0000h, code segment FFFFh and other segments 0000h.
- R2: If `insn_done_i` is seen in cycle k with `mreq_i`=1 and `ie_flag_i`=1 and no non-maskable request is pending, then `ack_o` is 1 in cycles k+1 and k+3 and 0 in k+2. `stall_o` is 1 in cycles k+1 to k+3.
- R3: The byte on `ack_vec_i` during the second acknowledge cycle appears on `take_type_o` in cycle k+4. In that cycle `take_o`, `clr_ie_o` and `flush_o` pulse high and `stall_o` returns to 0.
- R4: A maskable request is ignored when `ie_flag_i`=0 at the boundary, and also when no boundary strobe is present. In both cases no acknowledge, take or stall follows.
- R5: A rising edge on `nmi_i` is latched. At the next boundary it gives `take_o`=1 with `take_type_o`=NMI_TYPE (default 2) in the following cycle, with no acknowledge pulse and no stall, whatever `ie_flag_i` is.
- R6: When a non-maskable request is pending and a maskable request is also accepted at the same boundary, the non-maskable one is taken.
- R7: Holding `nmi_i` high yields only one take. A new take needs a new rising edge.
- R8: At a WAIT boundary (`wait_insn_i`=1) with `test_i`=0, the core is not stalled.
- R9: At a WAIT boundary with `test_i`=1, `stall_o` is 1 from the next cycle on. It drops one cycle after `test_i` is sampled at 0.
- R10: A non-maskable edge during the WAIT idle ends the stall and gives a take of type NMI_TYPE in the next cycle.
- R11: A non-maskable edge that arrives during an acknowledge sequence stays pending and is taken at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq_i | input | 1 | Maskable interrupt request level |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| ie_flag_i | input | 1 | Current interrupt-enable flag |
| test_i | input | 1 | TEST input; 1 keeps a WAIT idle |
| insn_done_i | input | 1 | Instruction boundary strobe |
| wait_insn_i | input | 1 | Finishing instruction is WAIT |
| ack_vec_i | input | VEC_W | Vector type byte driven during acknowledge |
| take_o | output | 1 | One-cycle interrupt take pulse |
| take_type_o | output | VEC_W | Type of the interrupt being taken |
| ack_o | output | 1 | Interrupt acknowledge pulse |
| stall_o | output | 1 | Hold the core |
| clr_ie_o | output | 1 | Request to clear the enable flag |
| flush_o | output | 1 | Empty the prefetch queue |
| init_load_o | output | 1 | Load the reset register values |
| rst_flags_o | output | REG_W | Flag word after reset |
| rst_ip_o | output | REG_W | Instruction pointer after reset |
| rst_cs_o | output | REG_W | Code segment after reset |
| rst_seg_o | output | REG_W | Data, stack and extra segments after reset |

## Verification
The bench goes after the collision of a pending non-maskable edge with an accepted maskable request. A wrong priority would start acknowledge pulses and report the vector byte instead of type 2. It holds `nmi_i` high across two boundaries, where a level-sensitive latch would take twice. It raises the edge in the middle of an acknowledge sequence, where a design that dropped it would never serve it. It wakes a WAIT idle with an edge, where a design that ignored it would stall until TEST fell. It also sets the vector byte only in the gap before the second pulse, so that sampling on the first pulse gives the wrong type.

// File: rtl/iwc_pkg.sv
package iwc_pkg;

    typedef enum logic [2:0] {
        S_RUN  = 3'd0,
        S_ACK1 = 3'd1,
        S_GAP  = 3'd2,
        S_ACK2 = 3'd3,
        S_IDLE = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        DEC_NONE = 2'd0,
        DEC_NMI  = 2'd1,
        DEC_MASK = 2'd2,
        DEC_WAIT = 2'd3
    } boundary_dec_e;

    // Priority at a boundary: latched NMI, then enabled maskable request,
    // then WAIT with TEST high.
    function automatic boundary_dec_e decide(input logic nmi_now,
                                             input logic mreq,
                                             input logic ie,
                                             input logic wait_insn,
                                             input logic test);
        if (nmi_now)
            return DEC_NMI;
        else if (mreq && ie)
            return DEC_MASK;
        else if (wait_insn && test)
            return DEC_WAIT;
        else
            return DEC_NONE;
    endfunction

endpackage

// File: rtl/iwc_nmi_latch.sv
module iwc_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    input  logic clear_i,
    output logic nmi_now_o
);
    logic nmi_q;
    logic pend_q;
    logic edge_w;

    assign edge_w    = nmi_i & ~nmi_q;
    assign nmi_now_o = pend_q | edge_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            nmi_q  <= nmi_i;
            pend_q <= (pend_q | edge_w) & ~clear_i;
        end
    end
endmodule

// File: rtl/iwc_seq.sv
module iwc_seq
    import iwc_pkg::*;
#(
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] NMI_TYPE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_now_i,
    input  logic             mreq_i,
    input  logic             ie_flag_i,
    input  logic             test_i,
    input  logic             insn_done_i,
    input  logic             wait_insn_i,
    input  logic [VEC_W-1:0] ack_vec_i,
    output logic             nmi_clr_o,
    output logic             take_o,
    output logic [VEC_W-1:0] take_type_o,
    output logic             ack_o,
    output logic             stall_o
);
    seq_state_e    st_q, st_d;
    logic          take_q, take_d;
    logic [VEC_W-1:0] type_q, type_d;
    boundary_dec_e dec;

    always_comb begin
        dec       = decide(nmi_now_i, mreq_i, ie_flag_i, wait_insn_i, test_i);
        st_d      = st_q;
        take_d    = 1'b0;
        type_d    = type_q;
        nmi_clr_o = 1'b0;
        unique case (st_q)
            S_RUN: begin
                if (insn_done_i) begin
                    unique case (dec)
                        DEC_NMI: begin
                            take_d    = 1'b1;
                            type_d    = NMI_TYPE;
                            nmi_clr_o = 1'b1;
                        end
                        DEC_MASK: st_d = S_ACK1;
                        DEC_WAIT: st_d = S_IDLE;
                        default:  st_d = S_RUN;
                    endcase
                end
            end
            S_ACK1: st_d = S_GAP;
            S_GAP:  st_d = S_ACK2;
            S_ACK2: begin
                st_d   = S_RUN;
                take_d = 1'b1;
                type_d = ack_vec_i;
            end
            S_IDLE: begin
                if (nmi_now_i) begin
                    st_d      = S_RUN;
                    take_d    = 1'b1;
                    type_d    = NMI_TYPE;
                    nmi_clr_o = 1'b1;
                end else if (!test_i) begin
                    st_d = S_RUN;
                end
            end
            default: st_d = S_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_RUN;
            take_q <= 1'b0;
            type_q <= '0;
        end else begin
            st_q   <= st_d;
            take_q <= take_d;
            type_q <= type_d;
        end
    end

    assign take_o      = take_q;
    assign take_type_o = type_q;
    assign ack_o       = (st_q == S_ACK1) || (st_q == S_ACK2);
    assign stall_o     = (st_q != S_RUN);
endmodule

// File: rtl/iwc_init.sv
module iwc_init #(
    parameter int               REG_W      = 16,
    parameter logic [REG_W-1:0] FLAGS_INIT = '0,
    parameter logic [REG_W-1:0] IP_INIT    = '0,
    parameter logic [REG_W-1:0] CS_INIT    = '1,
    parameter logic [REG_W-1:0] SEG_INIT   = '0
) (
    input  logic             clk,
    input  logic             rst,
    output logic             init_load_o,
    output logic [REG_W-1:0] flags_o,
    output logic [REG_W-1:0] ip_o,
    output logic [REG_W-1:0] cs_o,
    output logic [REG_W-1:0] seg_o
);
    logic init_q;

    always_ff @(posedge clk) begin
        init_q <= rst;
    end

    assign init_load_o = init_q | rst;
    assign flags_o     = FLAGS_INIT;
    assign ip_o        = IP_INIT;
    assign cs_o        = CS_INIT;
    assign seg_o       = SEG_INIT;
endmodule

// File: rtl/intwait_ctl.sv
module intwait_ctl #(
    parameter int               VEC_W    = 8,
    parameter int               REG_W    = 16,
    parameter logic [VEC_W-1:0] NMI_TYPE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mreq_i,
    input  logic             nmi_i,
    input  logic             ie_flag_i,
    input  logic             test_i,
    input  logic             insn_done_i,
    input  logic             wait_insn_i,
    input  logic [VEC_W-1:0] ack_vec_i,
    output logic             take_o,
    output logic [VEC_W-1:0] take_type_o,
    output logic             ack_o,
    output logic             stall_o,
    output logic             clr_ie_o,
    output logic             flush_o,
    output logic             init_load_o,
    output logic [REG_W-1:0] rst_flags_o,
    output logic [REG_W-1:0] rst_ip_o,
    output logic [REG_W-1:0] rst_cs_o,
    output logic [REG_W-1:0] rst_seg_o
);
    logic nmi_now;
    logic nmi_clr;

    iwc_nmi_latch u_nmi (
        .clk       (clk),
        .rst       (rst),
        .nmi_i     (nmi_i),
        .clear_i   (nmi_clr),
        .nmi_now_o (nmi_now)
    );

    iwc_seq #(.VEC_W(VEC_W), .NMI_TYPE(NMI_TYPE)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .nmi_now_i   (nmi_now),
        .mreq_i      (mreq_i),
        .ie_flag_i   (ie_flag_i),
        .test_i      (test_i),
        .insn_done_i (insn_done_i),
        .wait_insn_i (wait_insn_i),
        .ack_vec_i   (ack_vec_i),
        .nmi_clr_o   (nmi_clr),
        .take_o      (take_o),
        .take_type_o (take_type_o),
        .ack_o       (ack_o),
        .stall_o     (stall_o)
    );

    iwc_init #(.REG_W(REG_W)) u_init (
        .clk         (clk),
        .rst         (rst),
        .init_load_o (init_load_o),
        .flags_o     (rst_flags_o),
        .ip_o        (rst_ip_o),
        .cs_o        (rst_cs_o),
        .seg_o       (rst_seg_o)
    );

    // Any take forces the enable flag low and empties the queue.
    assign clr_ie_o = take_o;
    assign flush_o  = take_o | init_load_o;
endmodule

// File: rtl/intwait_ctl_chk.sv
module intwait_ctl_chk (
    input logic clk,
    input logic rst,
    input logic mreq_i,
    input logic ie_flag_i,
    input logic test_i,
    input logic insn_done_i,
    input logic take_o,
    input logic ack_o,
    input logic stall_o,
    input logic init_load_o
);
    // R2: acknowledge pulses are single cycles separated by a gap
    a_r2_ack_gap: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    // R2: the core is held while acknowledging
    a_r2_ack_stalls: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> stall_o);

    // R3: the second pulse is followed by the take
    a_r3_take_after_second: assert property (@(posedge clk) disable iff (rst)
        (ack_o && $past(stall_o) && !$past(ack_o)) |=> take_o);

    // R4: a first pulse needs an enabled request at a boundary
    a_r4_ack_needs_cause: assert property (@(posedge clk) disable iff (rst)
        (ack_o && !$past(ack_o) && !$past(stall_o))
            |-> $past(insn_done_i && mreq_i && ie_flag_i));

    // R5: a take never overlaps an acknowledge pulse or a stall
    a_r5_take_no_ack: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (!ack_o && !stall_o));

    // R9: leaving the idle without a take means TEST was low
    a_r9_idle_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(stall_o) && !stall_o && !$past(ack_o) && !take_o)
            |-> $past(!test_i));

    // R1: the reset load happens with the core free to run
    a_r1_init_no_stall: assert property (@(posedge clk) disable iff (rst)
        init_load_o |-> !stall_o);
endmodule

bind intwait_ctl intwait_ctl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .mreq_i      (mreq_i),
    .ie_flag_i   (ie_flag_i),
    .test_i      (test_i),
    .insn_done_i (insn_done_i),
    .take_o      (take_o),
    .ack_o       (ack_o),
    .stall_o     (stall_o),
    .init_load_o (init_load_o)
);

// File: tb/intwait_ctl_tb_top.sv
module intwait_ctl_tb_top;
    localparam int VEC_W = 8;
    localparam int REG_W = 16;

    logic clk = 1'b0;
    logic rst, mreq, nmi, ie, test, done, wait_insn;
    logic [VEC_W-1:0] vec;
    logic take, ack, stall, clr_ie, flush, init_load;
    logic [VEC_W-1:0] ttype;
    logic [REG_W-1:0] r_flags, r_ip, r_cs, r_seg;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    intwait_ctl dut_i (
        .clk(clk), .rst(rst), .mreq_i(mreq), .nmi_i(nmi), .ie_flag_i(ie),
        .test_i(test), .insn_done_i(done), .wait_insn_i(wait_insn),
        .ack_vec_i(vec), .take_o(take), .take_type_o(ttype), .ack_o(ack),
        .stall_o(stall), .clr_ie_o(clr_ie), .flush_o(flush),
        .init_load_o(init_load), .rst_flags_o(r_flags), .rst_ip_o(r_ip),
        .rst_cs_o(r_cs), .rst_seg_o(r_seg)
    );

    function automatic logic exp_accept(input logic m, input logic e);
        return m & e;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Boundary in the current cycle; returns after the edge that sampled it.
    task automatic boundary(input logic m, input logic e, input logic w, input logic t);
        mreq = m; ie = e; wait_insn = w; test = t; done = 1'b1;
        step();
        done = 1'b0; wait_insn = 1'b0; mreq = 1'b0;
    endtask

    // Remaining cycles of an accepted maskable request; called at k+1.
    task automatic ack_seq(input logic [VEC_W-1:0] v, input string tag);
        vec = ~v;
        check({tag, " R2 ack1"}, {ack, stall}, 2'b11);
        step();
        check({tag, " R2 gap"}, {ack, stall}, 2'b01);
        vec = v;
        step();
        check({tag, " R2 ack2"}, {ack, stall}, 2'b11);
        step();
        vec = ~v;
        check({tag, " R3 take"}, {take, clr_ie, flush, stall}, 4'b1110);
        check({tag, " R3 type"}, ttype, v);
        step();
        check({tag, " R3 take pulse ends"}, take, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; mreq = 0; nmi = 0; ie = 0; test = 0; done = 0; wait_insn = 0; vec = '0;
        step(); step();
        check("R1 init during reset", {init_load, flush}, 2'b11);
        rst = 1'b0;
        check("R1 init after release", {init_load, flush}, 2'b11);
        check("R1 idle outputs", {take, ack, stall}, 3'b000);
        check("R1 flags", r_flags, 16'h0000);
        check("R1 ip", r_ip, 16'h0000);
        check("R1 cs", r_cs, 16'hFFFF);
        check("R1 seg", r_seg, 16'h0000);
        step();
        check("R1 init drops", init_load, 1'b0);

        // R2 / R3 directed
        boundary(1, 1, 0, 0);
        ack_seq(8'hA5, "dir");

        // R4: disabled flag, and request without boundary
        boundary(1, 0, 0, 0);
        check("R4 masked ignored", {ack, take, stall}, 3'b000);
        mreq = 1; ie = 1; step();
        check("R4 no boundary", {ack, take, stall}, 3'b000);
        step();
        check("R4 no boundary later", {ack, take, stall}, 3'b000);
        mreq = 0;

        // R5 / R7: NMI with flag clear, level held
        nmi = 1; step();
        check("R5 not before boundary", take, 1'b0);
        boundary(0, 0, 0, 0);
        check("R5 nmi take", {take, ack, stall, clr_ie}, 4'b1001);
        check("R5 nmi type", ttype, 8'd2);
        boundary(0, 0, 0, 0);
        check("R7 level no retake", take, 1'b0);
        nmi = 0; step();

        // R6: NMI wins over enabled maskable request
        nmi = 1; step(); nmi = 0;
        boundary(1, 1, 0, 0);
        check("R6 nmi wins", {take, ack}, 2'b10);
        check("R6 type", ttype, 8'd2);
        step();
        check("R6 no ack after", {ack, stall}, 2'b00);

        // R8: WAIT with TEST low
        boundary(0, 0, 1, 0);
        check("R8 wait passes", stall, 1'b0);

        // R9: WAIT with TEST high
        boundary(0, 0, 1, 1);
        check("R9 stall", stall, 1'b1);
        step();
        check("R9 still stalled", stall, 1'b1);
        test = 0; step();
        check("R9 released", {stall, take}, 2'b00);

        // R10: NMI ends WAIT idle
        boundary(0, 0, 1, 1);
        check("R10 idle", stall, 1'b1);
        nmi = 1; step(); nmi = 0;
        check("R10 nmi wakes", {take, stall}, 2'b10);
        check("R10 type", ttype, 8'd2);
        test = 0;

        // R11: NMI edge inside acknowledge sequence
        boundary(1, 1, 0, 0);
        check("R11 ack1", ack, 1'b1);
        nmi = 1; step(); nmi = 0;
        vec = 8'h3C; step(); step();
        check("R11 masked take", {take, ttype}, {1'b1, 8'h3C});
        boundary(0, 0, 0, 0);
        check("R11 pending nmi", {take, ttype}, {1'b1, 8'd2});

        // Random mix of maskable requests at boundaries (R2 R3 R4)
        for (int i = 0; i < 40; i++) begin
            logic m, e;
            logic [VEC_W-1:0] v;
            m = 1'($urandom_range(0, 1));
            e = 1'($urandom_range(0, 1));
            v = 8'($urandom);
            boundary(m, e, 0, 0);
            if (exp_accept(m, e))
                ack_seq(v, "rnd");
            else
                check("R4 rnd ignored", {ack, take, stall}, 3'b000);
            repeat ($urandom_range(0, 3)) step();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule